// File: doc/BRIEF.md
# Compare-Match Output Waveform Unit

This unit sits beside a timer counter and turns its compare events into two output pin levels, channel A and channel B. Each cycle it takes per-channel match pulses, a TOP strobe, the count direction, the current TOP value and each channel's compare value. A 2-bit action code per channel and a 3-bit waveform mode select one of three behaviours: plain (non-PWM), fast PWM or phase-correct PWM. In each behaviour the pin is left alone, toggled, set or cleared.

Each channel also drives an enable that tells the pad logic to replace the normal port function with the pin level. Force strobes apply a channel's action at once, but only in plain modes. A compare value equal to TOP is handled as a special case so that the output can sit at a constant level. All outputs are registered and change one clock after the inputs that cause them.

Waveform mode encoding: `wave_mode[1:0]` = 00 or 10 selects plain, 11 selects fast PWM and 01 selects phase-correct PWM. `wave_mode[2]` only changes how code 01 behaves on channel A in the PWM modes.

Top module: `ocu_wave_out`

## Requirements
- R1: While `rst_n` is low and after its release, before any event, `pin_a`, `pin_b`, `oe_a` and `oe_b` are 0.
- R2: In plain mode a match applies the channel's code one cycle later: 01 inverts the pin, 10 drives it to 0, 11 drives it to 1.
- R3: In plain mode a force strobe has the same effect as a match. A match and a force in the same cycle change the pin only once, so code 01 inverts it exactly once.
- R4: In fast PWM and phase-correct PWM, force strobes have no effect on the pin.
- R5: In fast PWM with code 10 a match drives the pin to 0 and TOP drives it to 1. With code 11 a match drives it to 1 and TOP drives it to 0.
- R6: In phase-correct PWM with code 10 a match drives the pin to 0 while counting up (`count_down`=0) and to 1 while counting down. Code 11 does the reverse.
- R7: In either PWM mode, when the channel's compare value equals `top_val` and code bit 1 is set, a match has no effect. At a TOP strobe the pin goes to 1 for code 10 and to 0 for code 11, even if a match arrives in the same cycle.
- R8: In the PWM modes code 01 on channel A inverts the pin on a match when `wave_mode[2]`=1. It is disconnected (enable 0, pin held) when `wave_mode[2]`=0. Code 01 on channel B is always disconnected in PWM and its pin is held.
- R9: One cycle after a code is presented, the channel enable is 1 exactly when the channel is connected: any nonzero code in plain mode, and in PWM mode code 10, 11, or 01 on channel A with `wave_mode[2]`=1.
- R10: Code 00 makes the channel disconnected: its enable is 0 and matches do not change its pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wave_mode | input | 3 | Waveform mode select |
| count_down | input | 1 | Counter is counting down |
| at_top | input | 1 | Counter has reached TOP this cycle |
| top_val | input | CNT_W | Current TOP value |
| cmp_a | input | CNT_W | Channel A compare value |
| cmp_b | input | CNT_W | Channel B compare value |
| match_a | input | 1 | Channel A compare match pulse |
| match_b | input | 1 | Channel B compare match pulse |
| force_a | input | 1 | Channel A forced-compare strobe |
| force_b | input | 1 | Channel B forced-compare strobe |
| code_a | input | 2 | Channel A action code |
| code_b | input | 2 | Channel B action code |
| pin_a | output | 1 | Channel A pin level |
| pin_b | output | 1 | Channel B pin level |
| oe_a | output | 1 | Channel A overrides port function |
| oe_b | output | 1 | Channel B overrides port function |

## Verification
The bench targets the places where one code means different things. A match and a force that arrive together must invert the pin once; a design that handled them as two events would leave the pin unchanged. Forces are sent in PWM modes, where a design that honoured them would move the pin. Code 01 is driven on both channels with each setting of `wave_mode[2]`, which exposes a channel B that toggles or a channel A that ignores the mode bit. Compare values equal to TOP are used with both high codes and both PWM types. A design that let such a match through would glitch the pin, and one that skipped the TOP action would leave it at the wrong level.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
   typedef enum logic [1:0] {
      WK_PLAIN = 2'd0,
      WK_FAST  = 2'd1,
      WK_PHASE = 2'd2
   } wave_kind_e;

   function automatic wave_kind_e kind_of(input logic [2:0] mode);
      case (mode[1:0])
         2'b11:   kind_of = WK_FAST;
         2'b01:   kind_of = WK_PHASE;
         default: kind_of = WK_PLAIN;
      endcase
   endfunction
endpackage

// File: rtl/ocu_mode_decode.sv
module ocu_mode_decode
   import ocu_pkg::*;
(
   input  logic [2:0]  wave_mode,
   output wave_kind_e  kind,
   output logic        alt_toggle
);
   always_comb begin
      kind       = kind_of(wave_mode);
      alt_toggle = wave_mode[2];
   end
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel
   import ocu_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter bit HAS_ALT_01 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wave_kind_e       kind,
   input  logic             alt_toggle,
   input  logic             count_down,
   input  logic             at_top,
   input  logic [CNT_W-1:0] top_val,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             match,
   input  logic             force_cmp,
   input  logic [1:0]       code,
   output logic             pin_o,
   output logic             oe_o
);
   logic alt_ok;
   logic connected;
   logic toggle_pwm;
   logic top_eq;
   logic pin_nxt;

   generate
      if (HAS_ALT_01) begin : g_alt
         assign alt_ok = alt_toggle;
      end else begin : g_noalt
         assign alt_ok = 1'b0;
      end
   endgenerate

   assign top_eq     = (cmp_val == top_val);
   assign toggle_pwm = (code == 2'b01) && alt_ok;

   always_comb begin
      if (kind == WK_PLAIN) connected = (code != 2'b00);
      else                  connected = code[1] | toggle_pwm;
   end

   always_comb begin
      pin_nxt = pin_o;
      unique case (kind)
         WK_FAST: begin
            if (code[1]) begin
               if (at_top)               pin_nxt = ~code[0];
               else if (match && !top_eq) pin_nxt = code[0];
            end else if (toggle_pwm && match) begin
               pin_nxt = ~pin_o;
            end
         end
         WK_PHASE: begin
            if (code[1]) begin
               if (top_eq) begin
                  if (at_top) pin_nxt = ~code[0];
               end else if (match) begin
                  pin_nxt = code[0] ^ count_down;
               end
            end else if (toggle_pwm && match) begin
               pin_nxt = ~pin_o;
            end
         end
         default: begin
            if (match || force_cmp) begin
               case (code)
                  2'b01:   pin_nxt = ~pin_o;
                  2'b10:   pin_nxt = 1'b0;
                  2'b11:   pin_nxt = 1'b1;
                  default: pin_nxt = pin_o;
               endcase
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_o <= 1'b0;
         oe_o  <= 1'b0;
      end else begin
         pin_o <= pin_nxt;
         oe_o  <= connected;
      end
   end

   AST_CODE0_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b00) |=> !oe_o); // R10
   AST_CODE0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 2'b00) |=> (pin_o == $past(pin_o))); // R10
   AST_PWM_FORCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != WK_PLAIN && !match && !at_top) |=> (pin_o == $past(pin_o))); // R4
   AST_FAST_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == WK_FAST && code[1] && at_top) |=> (pin_o == !$past(code[0]))); // R5
   AST_PLAIN_ONE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == WK_PLAIN && code == 2'b01 && match && force_cmp) |=> (pin_o != $past(pin_o))); // R3
   AST_TOPEQ_MATCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != WK_PLAIN && code[1] && top_eq && match && !at_top) |=> (pin_o == $past(pin_o))); // R7
endmodule

// File: rtl/ocu_wave_out.sv
module ocu_wave_out
   import ocu_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       wave_mode,
   input  logic             count_down,
   input  logic             at_top,
   input  logic [CNT_W-1:0] top_val,
   input  logic [CNT_W-1:0] cmp_a,
   input  logic [CNT_W-1:0] cmp_b,
   input  logic             match_a,
   input  logic             match_b,
   input  logic             force_a,
   input  logic             force_b,
   input  logic [1:0]       code_a,
   input  logic [1:0]       code_b,
   output logic             pin_a,
   output logic             pin_b,
   output logic             oe_a,
   output logic             oe_b
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("ocu_wave_out: CNT_W must be at least 2");
      end
   endgenerate

   wave_kind_e kind;
   logic       alt_toggle;

   ocu_mode_decode u_dec (
      .wave_mode  (wave_mode),
      .kind       (kind),
      .alt_toggle (alt_toggle)
   );

   ocu_channel #(.CNT_W(CNT_W), .HAS_ALT_01(1'b1)) u_chan_a (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind       (kind),
      .alt_toggle (alt_toggle),
      .count_down (count_down),
      .at_top     (at_top),
      .top_val    (top_val),
      .cmp_val    (cmp_a),
      .match      (match_a),
      .force_cmp  (force_a),
      .code       (code_a),
      .pin_o      (pin_a),
      .oe_o       (oe_a)
   );

   ocu_channel #(.CNT_W(CNT_W), .HAS_ALT_01(1'b0)) u_chan_b (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind       (kind),
      .alt_toggle (alt_toggle),
      .count_down (count_down),
      .at_top     (at_top),
      .top_val    (top_val),
      .cmp_val    (cmp_b),
      .match      (match_b),
      .force_cmp  (force_b),
      .code       (code_b),
      .pin_o      (pin_b),
      .oe_o       (oe_b)
   );

   AST_B01_PWM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_mode[1:0] != 2'b00 && wave_mode[1:0] != 2'b10 && code_b == 2'b01) |=> !oe_b); // R8
   AST_A01_PWM_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_mode[1:0] == 2'b11 && wave_mode[2] && code_a == 2'b01) |=> oe_a); // R8
endmodule

// File: tb/ocu_wave_out_bench.sv
module ocu_wave_out_bench;
   localparam int W = 8;

   typedef struct {
      logic  pa, pb, oa, ob;
      string req;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   wave_mode = 3'b000;
   logic         count_down = 1'b0, at_top = 1'b0;
   logic [W-1:0] top_val = 8'd200, cmp_a = 8'd50, cmp_b = 8'd60;
   logic         match_a = 1'b0, match_b = 1'b0, force_a = 1'b0, force_b = 1'b0;
   logic [1:0]   code_a = 2'b00, code_b = 2'b00;
   logic         pin_a, pin_b, oe_a, oe_b;

   int   checks = 0;
   int   errors = 0;
   exp_t q[$];
   bit   done = 1'b0;

   always #10 clk = ~clk;

   ocu_wave_out #(.CNT_W(W)) u_ocu_wave_out (
      .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .count_down(count_down),
      .at_top(at_top), .top_val(top_val), .cmp_a(cmp_a), .cmp_b(cmp_b),
      .match_a(match_a), .match_b(match_b), .force_a(force_a), .force_b(force_b),
      .code_a(code_a), .code_b(code_b), .pin_a(pin_a), .pin_b(pin_b),
      .oe_a(oe_a), .oe_b(oe_b)
   );

   task automatic compare(input exp_t e);
      checks++;
      if ({pin_a, pin_b, oe_a, oe_b} !== {e.pa, e.pb, e.oa, e.ob}) begin
         errors++;
         $display("FAIL %s: got pa=%b pb=%b oa=%b ob=%b expected pa=%b pb=%b oa=%b ob=%b",
                  e.req, pin_a, pin_b, oe_a, oe_b, e.pa, e.pb, e.oa, e.ob);
      end
   endtask

   // monitor: results are registered, so the item pushed before an edge is checked just after it
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) compare(q.pop_front());
   end

   task automatic step(input logic [2:0] m, input logic dn, input logic tp,
                       input logic ma, input logic mb, input logic fa, input logic fb,
                       input logic [1:0] ca, input logic [1:0] cb,
                       input logic epa, input logic epb, input logic eoa, input logic eob,
                       input string req);
      exp_t e;
      @(negedge clk);
      wave_mode = m; count_down = dn; at_top = tp;
      match_a = ma; match_b = mb; force_a = fa; force_b = fb;
      code_a = ca; code_b = cb;
      e.pa = epa; e.pb = epb; e.oa = eoa; e.ob = eob; e.req = req;
      q.push_back(e);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      compare('{pa:0, pb:0, oa:0, ob:0, req:"R1 in reset"});
      @(negedge clk);
      rst_n = 1'b1;
      step(3'b000,0,0, 0,0,0,0, 2'b00,2'b00, 0,0,0,0, "R1 after release");
      // plain mode
      step(3'b000,0,0, 0,0,0,0, 2'b01,2'b11, 0,0,1,1, "R9 plain enables");
      step(3'b000,0,0, 1,1,0,0, 2'b01,2'b11, 1,1,1,1, "R2 toggle/set");
      step(3'b000,0,0, 1,0,0,0, 2'b01,2'b11, 0,1,1,1, "R2 toggle back");
      step(3'b000,0,0, 0,0,1,0, 2'b11,2'b11, 1,1,1,1, "R3 force set");
      step(3'b000,0,0, 1,0,1,0, 2'b01,2'b11, 0,1,1,1, "R3 match+force one toggle");
      step(3'b000,0,0, 0,0,0,1, 2'b01,2'b10, 0,0,1,1, "R3 force clear B");
      step(3'b000,0,0, 1,0,0,0, 2'b01,2'b10, 1,0,1,1, "R2 toggle up");
      step(3'b000,0,0, 1,0,1,0, 2'b00,2'b10, 1,0,0,1, "R10 code 00 holds");
      // fast PWM
      step(3'b011,0,0, 0,0,1,1, 2'b10,2'b11, 1,0,1,1, "R4 force ignored fast");
      step(3'b011,0,0, 1,1,0,0, 2'b10,2'b11, 0,1,1,1, "R5 match");
      step(3'b011,0,1, 0,0,0,0, 2'b10,2'b11, 1,0,1,1, "R5 top");
      step(3'b011,0,0, 1,1,0,0, 2'b01,2'b01, 1,0,0,0, "R8 01 disconnected bit2=0");
      step(3'b111,0,0, 1,1,0,0, 2'b01,2'b01, 0,0,1,0, "R8 A toggles bit2=1, B off");
      // phase-correct PWM
      step(3'b001,0,0, 1,1,1,1, 2'b10,2'b11, 0,1,1,1, "R6 up-count match");
      step(3'b001,1,0, 1,1,0,0, 2'b10,2'b11, 1,0,1,1, "R6 down-count match");
      step(3'b001,1,0, 1,0,0,0, 2'b11,2'b11, 0,0,1,1, "R6 code 11 down");
      step(3'b001,0,0, 0,0,1,0, 2'b11,2'b00, 0,0,1,0, "R4 force ignored phase");
      // compare equals TOP
      @(negedge clk); cmp_a = top_val;
      step(3'b011,0,1, 0,0,0,0, 2'b10,2'b00, 1,0,1,0, "R7 fast top sets");
      step(3'b011,0,0, 1,0,0,0, 2'b10,2'b00, 1,0,1,0, "R7 fast match ignored");
      step(3'b011,0,1, 1,0,0,0, 2'b11,2'b00, 0,0,1,0, "R7 fast top clears");
      step(3'b001,0,1, 1,0,0,0, 2'b10,2'b00, 1,0,1,0, "R7 phase top action");
      step(3'b001,1,0, 1,0,0,0, 2'b11,2'b00, 1,0,1,0, "R7 phase match ignored");
      step(3'b000,0,0, 0,0,0,0, 2'b00,2'b00, 1,0,0,0, "R10 idle");
      repeat (3) @(posedge clk);
      #5;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule